// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a byte-wide serial memory on a two-wire bus. It runs on a fast system clock and oversamples the bus clock and data lines. Each line passes through a two-flop synchronizer and a short glitch filter. The block then finds Start and Stop conditions and clock edges. It receives the control byte and, for a write, two address bytes followed by data bytes. It acknowledges each byte it accepts by pulling the data line low through an open-drain enable. It serves reads from a 17-bit address pointer, one bit at a time. Toward the memory array it presents a pointer output, a read-data input and a valid/ready write port.

The control byte has the fixed device code in its top four bits, then a block bit, then two chip bits, with the direction bit last. The block bit becomes pointer bit 16, and the two address bytes fill bits 15..0. The pointer moves forward after every transferred byte. It wraps inside the 64K half it is in, so bit 16 never changes by counting. A page buffer and the timed programming cycle, if wanted, sit behind the write port.

Back-pressure on the write port: `mem_wr_valid_o` rises when a data byte completes. Address and data then hold steady until the cycle in which `mem_wr_ready_i` is high. The pointer advances on that handshake. The array must accept the byte before the next byte on the bus completes, which is at least nine bus clocks later. Read data is taken combinationally from `mem_rd_data_i` for the current `mem_addr_o`.

Top module: `sermem_slave`

## Requirements
- R1: After reset `sda_oe_o` is 0, `mem_wr_valid_o` is 0 and `mem_addr_o` is 0.
- R2: A control byte is bits 7..4 = 1010, bit 3 = block bit, bits 2..1 = chip bits, bit 0 = direction (1 read, 0 write). The slave acknowledges it only when the device code matches, the chip bits equal `chip_sel_i` and `chip_en_i` is 1. Otherwise it leaves SDA released until the next Start.
- R3: After a matching write control byte, the slave acknowledges the high address byte and then the low address byte, each on the ninth clock. The pointer becomes {block bit, high byte, low byte}.
- R4: Each data byte that follows the address bytes is acknowledged. It appears on the write port at the current pointer, with valid held and address and data stable until ready. The pointer then increments.
- R5: A repeated Start after the address bytes writes nothing and keeps the loaded pointer, so a following read returns the byte at that address.
- R6: A matching read control byte loads its block bit into pointer bit 16. The slave then transmits, MSB first, the byte at the pointer. The pointer increments after every transmitted byte, so a read with no address phase returns the byte after the last one accessed.
- R7: When the master acknowledges a read byte, the slave sends the next byte. The pointer wraps from 0FFFFh to 00000h and from 1FFFFh to 10000h, and the same wrap applies to writes.
- R8: After a read byte that the master does not acknowledge, the slave keeps SDA released through any further clocks until a Start or Stop.
- R9: After each detected SCL falling edge, `sda_oe_o` stays unchanged for at least HOLD_CYC system clocks.
- R10: A Start or Stop in the middle of a byte abandons the byte. A partly received data byte is never written, and a Start begins a new control byte.
- R11: Pulses on SCL or SDA shorter than FILT_LEN system clocks do not affect the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| chip_sel_i | input | 2 | Levels the chip bits of the control byte must equal |
| chip_en_i | input | 1 | Must be 1 for the slave to respond |
| mem_addr_o | output | 17 | Address pointer toward the array |
| mem_rd_data_i | input | 8 | Array byte at `mem_addr_o` |
| mem_wr_valid_o | output | 1 | Write request valid |
| mem_wr_ready_i | input | 1 | Array accepts the write this cycle |
| mem_wr_data_o | output | 8 | Byte to write at `mem_addr_o` |

## Verification
The assertions check several rules on every cycle. Start, Stop and clock edges never coincide. Counting never changes pointer bit 16. A pending write keeps its address and data until accepted. The output enable never moves in the cycle right after a clock fall. The slave never drives during a mismatched control acknowledge or after a read NACK. Only the bench scenarios can show the protocol results. These are the acknowledge pattern per control byte, the address and data logged on the write port, the random, current and sequential read values across both wrap points, and the absence of writes after repeated Starts and aborted bytes. The scenarios also show tolerance of short glitches and the measured output hold after each clock fall.

// File: rtl/sm_pkg.sv
package sm_pkg;
  localparam int unsigned ADDR_W = 17;
  localparam int unsigned OFS_W  = ADDR_W - 1;
  localparam logic [3:0]  DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_AH,
    ST_AL,
    ST_WD,
    ST_RD,
    ST_WAITP
  } sm_state_e;
endpackage

// File: rtl/sm_glitch_filt.sv
module sm_glitch_filt #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] != out_q) begin
        if (cnt_q == CW'(FILT_LEN - 1)) begin
          out_q <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign filt_o = out_q;
endmodule

// File: rtl/sm_bus_cond.sv
module sm_bus_cond #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [1:0] raw;
  logic [1:0] filt;
  logic       scl_q, sda_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    sm_glitch_filt #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (raw[g]),
      .filt_o(filt[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= filt[0];
      sda_q <= filt[1];
    end
  end

  assign sda_o   = filt[1];
  assign start_o = filt[0] & scl_q & sda_q & ~filt[1];
  assign stop_o  = filt[0] & scl_q & ~sda_q & filt[1];
  assign rise_o  = filt[0] & ~scl_q;
  assign fall_o  = ~filt[0] & scl_q;

  // R10: bus conditions and clock edges are mutually exclusive
  p_cond_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, stop_o, rise_o, fall_o}));
endmodule

// File: rtl/sm_addr_ptr.sv
module sm_addr_ptr
  import sm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_blk_i,
  input  logic              blk_i,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic [7:0]        byte_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ld_blk_i) begin
      ptr_q[ADDR_W-1] <= blk_i;
    end else if (ld_hi_i) begin
      ptr_q[OFS_W-1 -: 8] <= byte_i;
    end else if (ld_lo_i) begin
      ptr_q[7:0] <= byte_i;
    end else if (inc_i) begin
      ptr_q[OFS_W-1:0] <= ptr_q[OFS_W-1:0] + 1'b1;
    end
  end

  assign ptr_o = ptr_q;

  // R7: counting stays inside the current half
  p_half_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_blk_i && !ld_hi_i && !ld_lo_i) |=>
      (ptr_q[ADDR_W-1] == $past(ptr_q[ADDR_W-1])));
endmodule

// File: rtl/sermem_slave.sv
module sermem_slave
  import sm_pkg::*;
#(
  parameter int unsigned FILT_LEN = 3,
  parameter int unsigned HOLD_CYC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [1:0]        chip_sel_i,
  input  logic              chip_en_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rd_data_i,
  output logic              mem_wr_valid_o,
  input  logic              mem_wr_ready_i,
  output logic [7:0]        mem_wr_data_o
);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);

  logic sda_f, c_start, c_stop, c_rise, c_fall;

  sm_bus_cond #(.FILT_LEN(FILT_LEN)) u_cond (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .sda_o  (sda_f),
    .start_o(c_start),
    .stop_o (c_stop),
    .rise_o (c_rise),
    .fall_o (c_fall)
  );

  sm_state_e     st_q;
  logic [3:0]    bitcnt_q;
  logic          in_ack_q;
  logic          drive_q;
  logic          mack_q;
  logic [7:0]    shreg_q;
  logic          wr_valid_q;
  logic [7:0]    wr_data_q;
  logic [HW-1:0] hold_q;
  logic          oe_q;

  logic rx_st, byte_done, match, ld_blk, ld_hi, ld_lo, wr_fire, rd_step;

  assign rx_st     = (st_q == ST_CTRL) || (st_q == ST_AH) ||
                     (st_q == ST_AL)   || (st_q == ST_WD);
  assign byte_done = rx_st && c_fall && !in_ack_q && (bitcnt_q == 4'd8);
  assign match     = chip_en_i && (shreg_q[7:4] == DEV_CODE) &&
                     (shreg_q[2:1] == chip_sel_i);
  assign ld_blk    = byte_done && (st_q == ST_CTRL) && match;
  assign ld_hi     = byte_done && (st_q == ST_AH);
  assign ld_lo     = byte_done && (st_q == ST_AL);
  assign wr_fire   = wr_valid_q && mem_wr_ready_i;
  assign rd_step   = (st_q == ST_RD) && c_fall && !in_ack_q && (bitcnt_q == 4'd8);

  sm_addr_ptr u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_blk_i(ld_blk),
    .blk_i   (shreg_q[3]),
    .ld_hi_i (ld_hi),
    .ld_lo_i (ld_lo),
    .byte_i  (shreg_q),
    .inc_i   (wr_fire || rd_step),
    .ptr_o   (mem_addr_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      bitcnt_q   <= '0;
      in_ack_q   <= 1'b0;
      drive_q    <= 1'b0;
      mack_q     <= 1'b1;
      shreg_q    <= '0;
      wr_valid_q <= 1'b0;
      wr_data_q  <= '0;
    end else begin
      if (wr_fire) wr_valid_q <= 1'b0;
      if (c_start) begin
        st_q     <= ST_CTRL;
        bitcnt_q <= '0;
        in_ack_q <= 1'b0;
        drive_q  <= 1'b0;
      end else if (c_stop) begin
        st_q     <= ST_IDLE;
        bitcnt_q <= '0;
        in_ack_q <= 1'b0;
        drive_q  <= 1'b0;
      end else if (rx_st) begin
        if (c_rise && !in_ack_q) begin
          shreg_q  <= {shreg_q[6:0], sda_f};
          bitcnt_q <= bitcnt_q + 1'b1;
        end
        if (byte_done) begin
          in_ack_q <= 1'b1;
          if (st_q == ST_CTRL) begin
            if (match) drive_q <= 1'b1;
            else       st_q    <= ST_IDLE;
          end else begin
            drive_q <= 1'b1;
            if (st_q == ST_WD) begin
              wr_valid_q <= 1'b1;
              wr_data_q  <= shreg_q;
            end
          end
        end else if (c_fall && in_ack_q) begin
          in_ack_q <= 1'b0;
          bitcnt_q <= '0;
          drive_q  <= 1'b0;
          case (st_q)
            ST_CTRL: begin
              if (shreg_q[0]) begin
                st_q    <= ST_RD;
                shreg_q <= mem_rd_data_i;
                drive_q <= ~mem_rd_data_i[7];
              end else begin
                st_q <= ST_AH;
              end
            end
            ST_AH:   st_q <= ST_AL;
            ST_AL:   st_q <= ST_WD;
            default: st_q <= ST_WD;
          endcase
        end
      end else if (st_q == ST_RD) begin
        if (c_rise) begin
          if (!in_ack_q) bitcnt_q <= bitcnt_q + 1'b1;
          else           mack_q   <= sda_f;
        end
        if (c_fall) begin
          if (!in_ack_q && bitcnt_q != 4'd8) begin
            shreg_q <= {shreg_q[6:0], 1'b0};
            drive_q <= ~shreg_q[6];
          end else if (!in_ack_q) begin
            drive_q  <= 1'b0;
            in_ack_q <= 1'b1;
          end else if (!mack_q) begin
            in_ack_q <= 1'b0;
            bitcnt_q <= '0;
            shreg_q  <= mem_rd_data_i;
            drive_q  <= ~mem_rd_data_i[7];
          end else begin
            in_ack_q <= 1'b0;
            st_q     <= ST_WAITP;
          end
        end
      end
    end
  end

  // Output hold: the enable follows drive only after HOLD_CYC clocks past a fall.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      if (c_fall)              hold_q <= HW'(HOLD_CYC);
      else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
      if (hold_q == '0)        oe_q   <= drive_q;
    end
  end

  assign sda_oe_o       = oe_q;
  assign mem_wr_valid_o = wr_valid_q;
  assign mem_wr_data_o  = wr_data_q;

  // R9: the enable never moves right after a detected clock fall
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    c_fall |=> $stable(oe_q));

  // R4: a pending write holds address and data until accepted
  p_wr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_q && !mem_wr_ready_i && !c_start) |=>
      (wr_valid_q && $stable(wr_data_q) && $stable(mem_addr_o)));

  // R2: a control-byte acknowledge only for an enabled, matching device code
  p_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CTRL && in_ack_q && drive_q) |->
      (chip_en_i && shreg_q[7:4] == DEV_CODE));

  // R8: nothing is driven while waiting for the end after a NACK
  p_nack_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAITP) |-> !drive_q);
endmodule

// File: tb/sermem_slave_tb_top.sv
module sermem_slave_tb_top;
  localparam int HALF = 100;
  localparam int HOLD = 32;
  localparam logic [1:0] CS = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, gl = 1'b0;
  logic chip_en = 1'b1;
  logic slow = 1'b0;
  logic [2:0] cyc = '0;
  logic sda_oe, wr_valid, wr_ready;
  logic [16:0] mem_addr;
  logic [7:0] wr_data, rd_data;
  logic sda_line;

  int checks = 0, errors = 0, viol = 0;
  int wn = 0;
  logic [16:0] log_a [16];
  logic [7:0]  log_d [16];
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [16:0] a);
    return a[7:0] ^ {a[16], a[15:9]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] ctl(input logic blk, input logic [1:0] cs, input logic rw);
    return {4'b1010, blk, cs, rw};
  endfunction

  assign sda_line = m_sda & ~sda_oe;
  assign rd_data  = pat(mem_addr);
  assign wr_ready = slow ? (cyc == 3'd7) : 1'b1;

  always @(posedge clk) cyc <= cyc + 3'd1;

  always @(negedge clk)
    if (rst_n && wr_valid && wr_ready) begin
      if (wn < 16) begin
        log_a[wn] = mem_addr;
        log_d[wn] = wr_data;
      end
      wn++;
    end

  sermem_slave dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (m_scl & ~gl),
    .sda_i         (sda_line),
    .sda_oe_o      (sda_oe),
    .chip_sel_i    (CS),
    .chip_en_i     (chip_en),
    .mem_addr_o    (mem_addr),
    .mem_rd_data_i (rd_data),
    .mem_wr_valid_o(wr_valid),
    .mem_wr_ready_i(wr_ready),
    .mem_wr_data_o (wr_data)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start;
    m_sda = 1'b1; tick(HALF);
    m_scl = 1'b1; tick(HALF);
    m_sda = 1'b0; tick(HALF);
    m_scl = 1'b0; tick(5);
  endtask

  task automatic do_stop;
    m_sda = 1'b0; tick(HALF - 5);
    m_scl = 1'b1; tick(HALF);
    m_sda = 1'b1; tick(HALF);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; tick(HALF - 5);
      m_scl = 1'b1;
      if (glitch) begin
        tick(40); gl = 1'b1; tick(2); gl = 1'b0; tick(HALF - 42);
      end else begin
        tick(HALF);
      end
      m_scl = 1'b0; tick(5);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    send_bits(b, 8, glitch);
    m_sda = 1'b1; tick(HALF - 5);
    m_scl = 1'b1; tick(HALF - 5);
    ack = !sda_line;
    tick(5);
    m_scl = 1'b0; tick(5);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HALF - 5);
      m_scl = 1'b1; tick(HALF - 5);
      b[i] = sda_line;
      tick(5);
      m_scl = 1'b0; tick(30);
      if (i > 0 && sda_oe !== !b[i]) viol++;
    end
    m_sda = !mack; tick(HALF);
    m_scl = 1'b1; tick(HALF);
    m_scl = 1'b0; tick(5);
    m_sda = 1'b1;
  endtask

  task automatic set_addr(input logic blk, input logic [7:0] hi, input logic [7:0] lo, input string tag);
    bit a;
    do_start;
    send_byte(ctl(blk, CS, 1'b0), 1'b0, a); chk(a, {tag, " ctrl ack"}, a, 1);
    send_byte(hi, 1'b0, a);                 chk(a, {tag, " addr hi ack"}, a, 1);
    send_byte(lo, 1'b0, a);                 chk(a, {tag, " addr lo ack"}, a, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] b;
    int w0;
    tick(3);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    chk(wr_valid == 1'b0, "R1 wr_valid", wr_valid, 0);
    chk(mem_addr == 17'h0, "R1 mem_addr", mem_addr, 0);
    rst_n = 1'b1;
    tick(20);

    // R2 address matching
    do_start; send_byte(8'hB4, 1'b0, a); chk(!a, "R2 wrong code nack", a, 0);
    chk(sda_oe == 1'b0, "R2 released after mismatch", sda_oe, 0); do_stop;
    do_start; send_byte(ctl(1'b0, 2'b01, 1'b0), 1'b0, a); chk(!a, "R2 wrong chip bits nack", a, 0); do_stop;
    chip_en = 1'b0;
    do_start; send_byte(ctl(1'b0, CS, 1'b0), 1'b0, a); chk(!a, "R2 disabled nack", a, 0); do_stop;
    chip_en = 1'b1;
    do_start; send_byte(ctl(1'b0, CS, 1'b0), 1'b0, a); chk(a, "R2 match ack", a, 1); do_stop;

    // R3 / R4 byte write with back-pressure
    slow = 1'b1;
    w0 = wn;
    set_addr(1'b1, 8'h12, 8'h34, "R3");
    send_byte(8'hA5, 1'b0, a); chk(a, "R4 data ack", a, 1);
    do_stop;
    slow = 1'b0;
    chk(wn == w0 + 1, "R4 write count", wn - w0, 1);
    chk(log_a[w0] == 17'h11234, "R3 write addr", log_a[w0], 17'h11234);
    chk(log_d[w0] == 8'hA5, "R4 write data", log_d[w0], 8'hA5);
    chk(mem_addr == 17'h11235, "R4 pointer after write", mem_addr, 17'h11235);

    // R7 write wrap in lower half
    w0 = wn;
    set_addr(1'b0, 8'hFF, 8'hFF, "R7w");
    send_byte(8'h11, 1'b0, a);
    send_byte(8'h22, 1'b0, a);
    do_stop;
    chk(wn == w0 + 2, "R7 write count", wn - w0, 2);
    chk(log_a[w0] == 17'h0FFFF && log_d[w0] == 8'h11, "R7 write first", log_a[w0], 17'h0FFFF);
    chk(log_a[w0+1] == 17'h00000 && log_d[w0+1] == 8'h22, "R7 write wrap", log_a[w0+1], 17'h0);

    // R5 random read
    w0 = wn;
    set_addr(1'b0, 8'h56, 8'h78, "R5");
    do_start;
    send_byte(ctl(1'b0, CS, 1'b1), 1'b0, a); chk(a, "R5 read ctrl ack", a, 1);
    recv_byte(1'b0, b); do_stop;
    chk(b == pat(17'h05678), "R5 random read data", b, pat(17'h05678));
    chk(wn == w0, "R5 no write on repeated start", wn - w0, 0);

    // R6 current address read
    do_start; send_byte(ctl(1'b0, CS, 1'b1), 1'b0, a);
    recv_byte(1'b0, b); do_stop;
    chk(b == pat(17'h05679), "R6 current read data", b, pat(17'h05679));
    chk(mem_addr == 17'h0567A, "R6 pointer after read", mem_addr, 17'h0567A);

    // R7 sequential read across upper wrap
    set_addr(1'b1, 8'hFF, 8'hFE, "R7r");
    do_start; send_byte(ctl(1'b1, CS, 1'b1), 1'b0, a);
    for (int k = 0; k < 4; k++) begin
      logic [16:0] ea;
      ea = {1'b1, 16'hFFFE + 16'(k)};
      recv_byte(k < 3, b);
      chk(b == pat(ea), "R7 sequential upper", b, pat(ea));
    end
    // R8 extra clocks after NACK read as released
    recv_byte(1'b0, b);
    chk(b == 8'hFF, "R8 released after nack", b, 8'hFF);
    do_stop;

    // R7 lower wrap
    set_addr(1'b0, 8'hFF, 8'hFF, "R7l");
    do_start; send_byte(ctl(1'b0, CS, 1'b1), 1'b0, a);
    recv_byte(1'b1, b); chk(b == pat(17'h0FFFF), "R7 lower last", b, pat(17'h0FFFF));
    recv_byte(1'b0, b); chk(b == pat(17'h00000), "R7 lower wrap", b, pat(17'h0));
    do_stop;

    // R10 abort mid data byte by Stop
    w0 = wn;
    set_addr(1'b0, 8'h01, 8'h00, "R10");
    send_bits(8'hC3, 4, 1'b0);
    do_stop;
    chk(wn == w0, "R10 partial byte not written", wn - w0, 0);
    // R10 Start mid control byte, then a fresh control byte
    do_start; send_bits(8'hA0, 3, 1'b0);
    do_start; send_byte(ctl(1'b0, CS, 1'b1), 1'b0, a); chk(a, "R10 restart ack", a, 1);
    recv_byte(1'b0, b); do_stop;
    chk(b == pat(17'h00100), "R10 pointer kept", b, pat(17'h00100));

    // R11 glitches on SCL during every high phase
    w0 = wn;
    set_addr(1'b0, 8'h02, 8'h00, "R11");
    send_byte(8'h3C, 1'b1, a); chk(a, "R11 glitched byte ack", a, 1);
    do_stop;
    chk(wn == w0 + 1, "R11 write count", wn - w0, 1);
    chk(log_a[w0] == 17'h00200 && log_d[w0] == 8'h3C, "R11 glitched write", log_d[w0], 8'h3C);

    // R9 hold after falls during all read bytes
    chk(viol == 0, "R9 output hold", viol, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule